// File: doc/BRIEF.md
# Embedded-Clock Frame Aligner and Lock Detector

This block sits behind the bit-rate sampler of a serial link receiver. Each cycle of its bit clock carries one line bit. The line is built from 18-bit frames: a start bit that is always 1, sixteen payload bits with the least significant bit sent first, and a stop bit that is always 0. The stop-to-start step at each frame seam is the only clock information on the line. The block has no framing hint, so it looks for that 0-to-1 seam at every one of the 18 bit phases.

While it is hunting, the block cuts the stream into 18-bit windows and records where every rising step falls. A phase counts as a candidate when a rising step appears at it in two windows in a row. The block declares lock only after exactly one candidate, at the same phase, has held for a fixed number of consecutive windows. Patterns that repeat several rising steps in every frame keep more than one candidate alive, so the block refuses to lock on them.

Once locked, the block follows the seam. With each frame it hands out one payload word together with a one-cycle strobe, and it drives an active-low lock flag that moves in the same cycle as the word. When the seam is missing twice in a row, lock is lost and the hunt starts again by itself. A power-down input clears all state. An output-enable input blanks the word and the strobe without touching lock.

Top module: `eclk_aligner`

## Requirements
- R1: A phase is a clock candidate when a 0 bit followed by a 1 bit (stop then start) is seen at that phase in two consecutive 18-bit windows. The start bit is frame bit 0, payload bit i is frame bit i+1, and the stop bit is frame bit 17.
- R2: While hunting, lock is declared once a single candidate phase has persisted for LOCK_FRAMES (default 150) consecutive windows. With a steady training frame of payload 0x00FF, `lock_no` falls between 146 and 156 frames after the training starts.
- R3: Any window with no candidate restarts the persistence count from zero. After such a break, lock needs the full LOCK_FRAMES windows again.
- R4: While more than one candidate phase exists in each window (for example a repeated payload of 0x5555), `lock_no` stays high. Once the pattern changes to one with a single seam, lock is acquired within the R2 window.
- R5: When locked, each frame seam produces one `word_o` value with a one-cycle `word_stb_o`. The word holds the 16 payload bits of the frame just completed, bit i taken from frame bit i+1, and the words come out in the order the frames were sent.
- R6: `lock_no` is 1 after reset. `word_stb_o` is high only while `lock_no` is low. `lock_no` falls in the same cycle as the first word strobe.
- R7: A single frame whose seam is missing (stop bit sent as 1) keeps the lock. Two consecutive missing seams raise `lock_no` in the cycle after the second seam's start bit is sampled.
- R8: After loss of lock the block hunts again without outside help and relocks on training frames within the R2 window.
- R9: While `pd_i` is high, `lock_no` is 1 and `word_o` and `word_stb_o` are 0 from the next cycle on. After release, lock must be reacquired over at least LOCK_FRAMES windows.
- R10: While `oe_i` is low, `word_o` reads 0 and `word_stb_o` stays low, and the lock state is not changed. Words resume once `oe_i` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one line bit per rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_i | input | 1 | Recovered line bit |
| pd_i | input | 1 | Power-down, active high, clears lock and blanks outputs |
| oe_i | input | 1 | Output enable, low blanks word and strobe |
| word_o | output | 16 | Reassembled payload word |
| word_stb_o | output | 1 | One-cycle strobe marking a new word |
| lock_no | output | 1 | Lock flag, low while words are valid |

## Verification
A training frame with a single seam measures the acquisition time against the persistence count. A stream of varied words, including all-zero, all-one and single-bit payloads, then shows that bit order and word order survive once the position is fixed. A 0x5555 payload puts several rising steps in every frame and must never lock, which separates uniqueness from plain persistence. One and two corrupted stop bits tell tolerance apart from loss, and a single missing seam in mid-hunt shows that the count restarts. Power-down and output-enable pulses, each followed by a look at the lock flag and the word, show which of the two inputs disturbs lock and which only masks the outputs.

// File: rtl/eclk_pkg.sv
package eclk_pkg;

   // Bits on the line for one frame: start, payload, stop.
   function automatic int unsigned frame_bits(input int unsigned payload_w);
      return payload_w + 2;
   endfunction

   // Tracker state.
   typedef enum logic {
      TRK_HUNT   = 1'b0,
      TRK_LOCKED = 1'b1
   } trk_state_e;

endpackage

// File: rtl/eclk_edge_map.sv
// Free-running window phase, payload shifter and per-phase rising-step map.
module eclk_edge_map #(
   parameter int unsigned DATA_W    = 16,
   parameter bit          LSB_FIRST = 1'b1,
   localparam int unsigned FW       = eclk_pkg::frame_bits(DATA_W),
   localparam int unsigned PW       = $clog2(FW)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              ser_i,
   output logic [PW-1:0]     phase_o,
   output logic              rise_o,
   output logic [DATA_W-1:0] data_o,
   output logic [FW-1:0]     win_map_o,
   output logic              win_end_o
);

   // sr_q[DATA_W] is the previous bit (the stop bit at a seam),
   // sr_q[DATA_W-1:0] are the sixteen bits before it.
   logic [DATA_W:0]   sr_q;
   logic [PW-1:0]     ph_q;
   logic [FW-1:0]     map_q;

   assign rise_o    = ser_i & ~sr_q[DATA_W];
   assign phase_o   = ph_q;
   assign win_end_o = (ph_q == PW'(FW - 1));

   always_comb begin
      win_map_o        = map_q;
      win_map_o[ph_q]  = rise_o;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sr_q  <= '0;
         ph_q  <= '0;
         map_q <= '0;
      end else if (clr_i) begin
         sr_q  <= '0;
         ph_q  <= '0;
         map_q <= '0;
      end else begin
         sr_q        <= {ser_i, sr_q[DATA_W:1]};
         map_q[ph_q] <= rise_o;
         ph_q        <= win_end_o ? '0 : ph_q + 1'b1;
      end
   end

   // Payload order: the oldest shifted bit is the first one sent.
   generate
      if (LSB_FIRST) begin : g_lsb
         assign data_o = sr_q[DATA_W-1:0];
      end else begin : g_msb
         for (genvar i = 0; i < int'(DATA_W); i++) begin : g_rev
            assign data_o[i] = sr_q[DATA_W-1-i];
         end
      end
   endgenerate

endmodule

// File: rtl/eclk_qualifier.sv
// Window-to-window candidate filter and persistence counter.
module eclk_qualifier #(
   parameter int unsigned FW          = 18,
   parameter int unsigned LOCK_FRAMES = 150,
   localparam int unsigned PW         = $clog2(FW),
   localparam int unsigned CW         = $clog2(LOCK_FRAMES + 1)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          clr_i,
   input  logic          hunt_i,
   input  logic [FW-1:0] win_map_i,
   input  logic          win_end_i,
   output logic          acq_o,
   output logic [PW-1:0] acq_pos_o
);

   logic [FW-1:0] prev_q;
   logic [FW-1:0] cand;
   logic [PW-1:0] pos_q;
   logic [PW-1:0] hit_pos;
   logic [CW-1:0] run_q;
   logic [CW-1:0] run_nxt;
   logic          single;

   always_comb begin
      cand    = win_map_i & prev_q;
      hit_pos = '0;
      for (int i = 0; i < int'(FW); i++) begin
         if (cand[i]) hit_pos = PW'(i);
      end
      single = ($countones(cand) == 1);
      if (!single) begin
         run_nxt = '0;
      end else if ((run_q != '0) && (hit_pos == pos_q)) begin
         run_nxt = (run_q == CW'(LOCK_FRAMES)) ? run_q : run_q + 1'b1;
      end else begin
         run_nxt = CW'(1);
      end
   end

   assign acq_o     = hunt_i && !clr_i && win_end_i && single &&
                      (run_nxt == CW'(LOCK_FRAMES));
   assign acq_pos_o = hit_pos;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= '0;
         pos_q  <= '0;
         run_q  <= '0;
      end else if (clr_i || !hunt_i) begin
         prev_q <= '0;
         pos_q  <= '0;
         run_q  <= '0;
      end else if (win_end_i) begin
         prev_q <= win_map_i;
         pos_q  <= hit_pos;
         run_q  <= run_nxt;
      end
   end

endmodule

// File: rtl/eclk_tracker.sv
// Follows the acquired seam, emits words and manages the lock flag.
module eclk_tracker #(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned MISS_LIMIT = 2,
   localparam int unsigned FW        = eclk_pkg::frame_bits(DATA_W),
   localparam int unsigned PW        = $clog2(FW),
   localparam int unsigned MW        = $clog2(MISS_LIMIT + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic [PW-1:0]     phase_i,
   input  logic              rise_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              acq_i,
   input  logic [PW-1:0]     acq_pos_i,
   output logic              hunt_o,
   output logic [DATA_W-1:0] word_o,
   output logic              stb_o,
   output logic              lock_no
);

   import eclk_pkg::*;

   trk_state_e        st_q;
   logic [PW-1:0]     seam_q;
   logic [MW-1:0]     miss_q;

   assign hunt_o = (st_q == TRK_HUNT);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q    <= TRK_HUNT;
         seam_q  <= '0;
         miss_q  <= '0;
         word_o  <= '0;
         stb_o   <= 1'b0;
         lock_no <= 1'b1;
      end else if (clr_i) begin
         st_q    <= TRK_HUNT;
         seam_q  <= '0;
         miss_q  <= '0;
         word_o  <= '0;
         stb_o   <= 1'b0;
         lock_no <= 1'b1;
      end else begin
         stb_o <= 1'b0;
         unique case (st_q)
            TRK_HUNT: begin
               if (acq_i) begin
                  st_q   <= TRK_LOCKED;
                  seam_q <= acq_pos_i;
                  miss_q <= '0;
               end
            end
            TRK_LOCKED: begin
               if (phase_i == seam_q) begin
                  if (rise_i) begin
                     miss_q  <= '0;
                     word_o  <= data_i;
                     stb_o   <= 1'b1;
                     lock_no <= 1'b0;
                  end else if (miss_q == MW'(MISS_LIMIT - 1)) begin
                     st_q    <= TRK_HUNT;
                     miss_q  <= '0;
                     lock_no <= 1'b1;
                  end else begin
                     miss_q <= miss_q + 1'b1;
                     if (!lock_no) begin
                        word_o <= data_i;
                        stb_o  <= 1'b1;
                     end
                  end
               end
            end
            default: st_q <= TRK_HUNT;
         endcase
      end
   end

endmodule

// File: rtl/eclk_aligner.sv
// Top: embedded-clock frame aligner with lock detection.
module eclk_aligner #(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned LOCK_FRAMES = 150,
   parameter int unsigned MISS_LIMIT  = 2,
   parameter bit          LSB_FIRST   = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ser_i,
   input  logic              pd_i,
   input  logic              oe_i,
   output logic [DATA_W-1:0] word_o,
   output logic              word_stb_o,
   output logic              lock_no
);

   localparam int unsigned FW = eclk_pkg::frame_bits(DATA_W);
   localparam int unsigned PW = $clog2(FW);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("eclk_aligner: DATA_W must be at least 2");
      end
      if (LOCK_FRAMES < 1) begin : g_bad_lock
         $error("eclk_aligner: LOCK_FRAMES must be at least 1");
      end
      if (MISS_LIMIT < 1) begin : g_bad_miss
         $error("eclk_aligner: MISS_LIMIT must be at least 1");
      end
   endgenerate

   logic [PW-1:0]     phase;
   logic              rise;
   logic [DATA_W-1:0] data;
   logic [FW-1:0]     win_map;
   logic              win_end;
   logic              hunt;
   logic              acq;
   logic [PW-1:0]     acq_pos;
   logic [DATA_W-1:0] word_q;
   logic              stb_q;

   eclk_edge_map #(
      .DATA_W    (DATA_W),
      .LSB_FIRST (LSB_FIRST)
   ) u_map (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (pd_i),
      .ser_i     (ser_i),
      .phase_o   (phase),
      .rise_o    (rise),
      .data_o    (data),
      .win_map_o (win_map),
      .win_end_o (win_end)
   );

   eclk_qualifier #(
      .FW          (FW),
      .LOCK_FRAMES (LOCK_FRAMES)
   ) u_qual (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (pd_i),
      .hunt_i    (hunt),
      .win_map_i (win_map),
      .win_end_i (win_end),
      .acq_o     (acq),
      .acq_pos_o (acq_pos)
   );

   eclk_tracker #(
      .DATA_W     (DATA_W),
      .MISS_LIMIT (MISS_LIMIT)
   ) u_trk (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (pd_i),
      .phase_i   (phase),
      .rise_i    (rise),
      .data_i    (data),
      .acq_i     (acq),
      .acq_pos_i (acq_pos),
      .hunt_o    (hunt),
      .word_o    (word_q),
      .stb_o     (stb_q),
      .lock_no   (lock_no)
   );

   // Masking on the way out leaves the tracker state untouched.
   assign word_o     = (oe_i && !pd_i) ? word_q : '0;
   assign word_stb_o = oe_i && !pd_i && stb_q;

endmodule

// File: rtl/eclk_aligner_chk.sv
// Property checker, bound to every eclk_aligner instance.
module eclk_aligner_chk #(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned LOCK_FRAMES = 150
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              pd_i,
   input logic              oe_i,
   input logic [DATA_W-1:0] word_o,
   input logic              word_stb_o,
   input logic              lock_no
);

   localparam int unsigned FW       = DATA_W + 2;
   localparam int unsigned MIN_HUNT = (LOCK_FRAMES - 1) * FW;

   // Cycles spent with the lock flag high since it was last low.
   int unsigned hunt_cnt;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    hunt_cnt <= 0;
      else if (!lock_no)              hunt_cnt <= 0;
      else if (hunt_cnt != 32'hFFFF_FFFF) hunt_cnt <= hunt_cnt + 1;
   end

   // R6: a word strobe only while lock is shown
   a_r6_stb_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
      word_stb_o |-> !lock_no);

   // R6: lock falls together with the first word when outputs are enabled
   a_r6_lock_with_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(lock_no) && oe_i && !pd_i) |-> word_stb_o);

   // R5: at most one word per frame, never two strobes back to back
   a_r5_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      word_stb_o |=> !word_stb_o);

   // R9: power-down forces the lock flag high and blanks the word
   a_r9_pd_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(pd_i) |-> (lock_no && (word_o == '0)));

   // R2: lock cannot be shown before the persistence window has elapsed
   a_r2_min_hunt: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(lock_no) |-> (hunt_cnt >= MIN_HUNT));

endmodule

bind eclk_aligner eclk_aligner_chk #(
   .DATA_W      (DATA_W),
   .LOCK_FRAMES (LOCK_FRAMES)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .pd_i       (pd_i),
   .oe_i       (oe_i),
   .word_o     (word_o),
   .word_stb_o (word_stb_o),
   .lock_no    (lock_no)
);

// File: tb/sim_eclk_aligner.sv
module sim_eclk_aligner;

   localparam int          CLK_PERIOD = 10;
   localparam int          DW         = 16;
   localparam logic [15:0] TRAIN      = 16'h00FF;
   localparam int          LO_F       = 146;
   localparam int          HI_F       = 156;

   logic          clk    = 1'b0;
   logic          rst_n  = 1'b0;
   logic          ser    = 1'b0;
   logic          pd     = 1'b0;
   logic          oe     = 1'b1;
   logic [DW-1:0] word;
   logic          stb;
   logic          lock_n;

   int            checks = 0;
   int            errors = 0;
   logic [15:0]   rxq[$];
   bit            low_seen;
   bit            stb_seen;
   bit            nz_seen;

   always #(CLK_PERIOD/2) clk = ~clk;

   eclk_aligner #(
      .DATA_W      (DW),
      .LOCK_FRAMES (150),
      .MISS_LIMIT  (2),
      .LSB_FIRST   (1'b1)
   ) u0 (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .ser_i      (ser),
      .pd_i       (pd),
      .oe_i       (oe),
      .word_o     (word),
      .word_stb_o (stb),
      .lock_no    (lock_n)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Sample outputs at the falling edge, then drive the next line bit.
   task automatic drive_bit(input bit b);
      @(negedge clk);
      if (stb) begin
         rxq.push_back(word);
         stb_seen = 1'b1;
      end
      if (!lock_n)     low_seen = 1'b1;
      if (word != '0)  nz_seen  = 1'b1;
      ser = b;
   endtask

   task automatic send_frame(input logic [15:0] d, input bit stop);
      drive_bit(1'b1);
      for (int i = 0; i < DW; i++) drive_bit(d[i]);
      drive_bit(stop);
   endtask

   task automatic train_until_lock(input int maxf, output int n);
      n = 0;
      while (n < maxf) begin
         low_seen = 1'b0;
         send_frame(TRAIN, 1'b0);
         n++;
         if (low_seen) break;
      end
   endtask

   task automatic pd_pulse();
      pd = 1'b1;
      repeat (6) drive_bit(1'b0);
      pd = 1'b0;
   endtask

   task automatic t_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(lock_n == 1'b1, "R6", "lock flag after reset", int'(lock_n), 1);
      check(stb == 1'b0, "R6", "strobe after reset", int'(stb), 0);
      check(word == '0, "R6", "word after reset", int'(word), 0);
   endtask

   task automatic t_train();
      int n;
      train_until_lock(HI_F + 10, n);
      check(n >= LO_F && n <= HI_F, "R2", "frames to first lock", n, 151);
   endtask

   task automatic t_data();
      logic [15:0] exp[$];
      logic [15:0] lf;
      rxq.delete();
      exp.push_back(TRAIN);
      lf = 16'hACE1;
      foreach (exp[k]) begin end
      for (int k = 0; k < 20; k++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         exp.push_back(lf);
      end
      exp.push_back(16'h0000);
      exp.push_back(16'hFFFF);
      exp.push_back(16'h0001);
      exp.push_back(16'h8000);
      for (int k = 1; k < exp.size(); k++) send_frame(exp[k], 1'b0);
      send_frame(TRAIN, 1'b0);
      check(rxq.size() == exp.size(), "R5", "number of words", rxq.size(), exp.size());
      for (int k = 0; k < exp.size() && k < rxq.size(); k++)
         check(rxq[k] == exp[k], "R5", "word order and bit order (R1 framing)",
               int'(rxq[k]), int'(exp[k]));
      check(lock_n == 1'b0, "R6", "lock held over data", int'(lock_n), 0);
   endtask

   task automatic t_one_miss();
      send_frame(TRAIN, 1'b1);
      repeat (3) send_frame(TRAIN, 1'b0);
      check(lock_n == 1'b0, "R7", "lock after one missing seam", int'(lock_n), 0);
   endtask

   task automatic t_two_miss();
      send_frame(TRAIN, 1'b1);
      send_frame(TRAIN, 1'b1);
      @(negedge clk);
      check(lock_n == 1'b0, "R7", "lock before second seam check", int'(lock_n), 0);
      ser = 1'b1;
      @(negedge clk);
      check(lock_n == 1'b1, "R7", "lock lost at second missing seam", int'(lock_n), 1);
      ser = TRAIN[0];
      for (int i = 1; i < DW; i++) drive_bit(TRAIN[i]);
      drive_bit(1'b0);
   endtask

   task automatic t_resync();
      int n;
      train_until_lock(HI_F + 10, n);
      check(n >= LO_F && n <= HI_F, "R8", "frames to relock", n, 151);
   endtask

   task automatic t_oe();
      oe = 1'b0;
      stb_seen = 1'b0;
      nz_seen  = 1'b0;
      repeat (3) send_frame(16'h1357, 1'b0);
      check(!stb_seen, "R10", "strobe while disabled", int'(stb_seen), 0);
      check(!nz_seen, "R10", "word while disabled", int'(nz_seen), 0);
      check(lock_n == 1'b0, "R10", "lock kept while disabled", int'(lock_n), 0);
      oe = 1'b1;
      rxq.delete();
      send_frame(16'h2468, 1'b0);
      send_frame(TRAIN, 1'b0);
      check(rxq.size() == 2, "R10", "words after enable", rxq.size(), 2);
      if (rxq.size() > 0)
         check(rxq[rxq.size()-1] == 16'h2468, "R10", "word after enable",
               int'(rxq[rxq.size()-1]), 16'h2468);
   endtask

   task automatic t_pd();
      int n;
      pd = 1'b1;
      repeat (20) drive_bit(1'b1);
      check(lock_n == 1'b1, "R9", "lock in power-down", int'(lock_n), 1);
      check(word == '0, "R9", "word in power-down", int'(word), 0);
      check(stb == 1'b0, "R9", "strobe in power-down", int'(stb), 0);
      pd = 1'b0;
      low_seen = 1'b0;
      repeat (100) send_frame(TRAIN, 1'b0);
      check(!low_seen, "R9", "no early lock after release", int'(low_seen), 0);
      train_until_lock(80, n);
      check(n < 80, "R9", "relock after release", n, 52);
   endtask

   task automatic t_rmt();
      int n;
      pd_pulse();
      low_seen = 1'b0;
      repeat (200) send_frame(16'h5555, 1'b0);
      check(!low_seen, "R4", "no lock on repeated multi-step pattern", int'(low_seen), 0);
      train_until_lock(HI_F + 10, n);
      check(n >= LO_F - 2 && n <= HI_F, "R4", "lock after pattern change", n, 151);
   endtask

   task automatic t_break();
      int n;
      pd_pulse();
      repeat (100) send_frame(TRAIN, 1'b0);
      send_frame(TRAIN, 1'b1);
      low_seen = 1'b0;
      repeat (130) send_frame(TRAIN, 1'b0);
      check(!low_seen, "R3", "count restarted by a break", int'(low_seen), 0);
      train_until_lock(40, n);
      check(n < 40, "R3", "lock after full count", n, 22);
   endtask

   initial begin
      t_reset();
      t_train();
      t_data();
      t_one_miss();
      t_two_miss();
      t_resync();
      t_oe();
      t_pd();
      t_rmt();
      t_break();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule